// File: doc/BRIEF.md
# Wait-for-Interrupt Stall and Trap Unit

This unit sits beside the decode stage of a processor hart and handles two wait instructions: the ordinary wait-for-interrupt and a selective variant. The variant may ignore interrupts that are routed to a mode less privileged than the one currently running. When one of the two encodings arrives with a valid strobe, the unit holds the hart stalled until an enabled interrupt is pending. If the privilege mode and the interception bits say the wait may not idle indefinitely, the unit instead ends it with an exception after a fixed number of cycles.

The outcome is a single-cycle pulse. `wait_done` means the wait finished normally. `wait_exc` with a cause code means the wait must trap: cause 2 is illegal instruction and cause 22 is virtual instruction. `wait_stall` is low in the cycle of that pulse. The unit samples mode and control bits when the wait is accepted. It looks at pending, enable and routing vectors live in every cycle. Taking the interrupt itself, the control registers and the pipeline belong to the surrounding logic.

Top module: `wfi_wait_unit`

## Requirements
- R1: Only the words 0x10500073 (ordinary wait) and 0x00500073 (selective variant, bits 29:28 = 00) start a wait. Any other word, including 0x30500073, leaves stall, done and exception low.
- R2: An ordinary wait completes (`wait_done`, stall low) in the first cycle in which some interrupt has both its pending and enable bits set, counting the acceptance cycle as cycle 0.
- R3: Each interrupt has a 2-bit target rank (3 = M, 2 = S, 1 = VS, 0 = U/VU). The current mode ranks as follows: mode code 3 is M (3), code 1 is S (2), code 5 is VS (1), code 0 is U (0) and code 4 is VU (0). The variant keeps stalling while every enabled pending interrupt has a target rank below the current mode's rank.
- R4: With VARIANT_AS_PLAIN = 1, the variant wakes exactly like the ordinary wait.
- R5: In M mode a wait never traps; it stalls until woken.
- R6: With TW = 1 in S, U, VS or VU mode, a wait not woken before cycle TIMEOUT_CYCLES raises cause 2 in cycle TIMEOUT_CYCLES. When TIMEOUT_CYCLES = 0 this happens in cycle 0.
- R7: In U mode with S mode present, a wait traps with cause 2 on timeout even when TW = 0.
- R8: In VS mode with TW = 0 and VTW = 1, the timeout trap has cause 22. With both bits clear, a VS wait stalls until woken.
- R9: In VU mode with TW = 0, a wait traps with cause 22 on timeout.
- R10: When both traps apply (VS mode, TW = 1, VTW = 1), cause 2 is reported.
- R11: When a wake and the timeout fall in the same cycle, the trap wins.
- R12: Each accepted wait produces exactly one of done or exception, and stall is low in that cycle. A valid strobe arriving while a wait is stalled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| cur_mode | input | 3 | Current mode: 0 U, 1 S, 3 M, 4 VU, 5 VS |
| tw | input | 1 | Timeout-wait interception bit |
| vtw | input | 1 | Virtual timeout-wait interception bit |
| irq_pending | input | NUM_IRQ | Pending interrupt vector |
| irq_enable | input | NUM_IRQ | Interrupt enable vector |
| irq_target | input | 2*NUM_IRQ | Target rank per interrupt, 2 bits each |
| wait_stall | output | 1 | Hold the hart |
| wait_done | output | 1 | Wait completed normally |
| wait_exc | output | 1 | Wait must trap |
| exc_cause | output | 5 | Trap cause (2 or 22), 0 otherwise |

## Verification
The hardest case to reach from the ports is a wake that lands in exactly the timeout cycle, combined with a variant whose only pending interrupts are routed below the current mode. In that situation the routing filter, the interception rules and the counter all decide together. The stimulus picks the wake cycle at random across the timeout window, including the boundary value, so this coincidence occurs repeatedly. A second instance with a zero timeout and the variant treated as plain receives the same inputs, which exercises the immediate-trap path and the alternative wake rule side by side.

// File: rtl/wfi_wait_unit.sv
module wfi_wait_unit #(
  parameter int NUM_IRQ          = 16,
  parameter int TIMEOUT_CYCLES   = 4,
  parameter int HAS_SMODE        = 1,
  parameter int HAS_UMODE        = 1,
  parameter int VARIANT_AS_PLAIN = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 insn_valid,
  input  logic [31:0]          insn,
  input  logic [2:0]           cur_mode,
  input  logic                 tw,
  input  logic                 vtw,
  input  logic [NUM_IRQ-1:0]   irq_pending,
  input  logic [NUM_IRQ-1:0]   irq_enable,
  input  logic [2*NUM_IRQ-1:0] irq_target,
  output logic                 wait_stall,
  output logic                 wait_done,
  output logic                 wait_exc,
  output logic [4:0]           exc_cause
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 2);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);
  localparam logic [31:0] PLAIN_WORD = 32'h1050_0073;
  localparam logic [31:0] MINE_WORD  = 32'h0050_0073;
  localparam logic [2:0] MD_U = 3'd0, MD_S = 3'd1, MD_M = 3'd3, MD_VU = 3'd4, MD_VS = 3'd5;
  localparam logic [4:0] C_ILLEGAL = 5'd2, C_VIRTUAL = 5'd22;

  function automatic logic [1:0] rank_of(input logic [2:0] m);
    case (m)
      MD_S:    rank_of = 2'd2;
      MD_VS:   rank_of = 2'd1;
      MD_U,
      MD_VU:   rank_of = 2'd0;
      default: rank_of = 2'd3;
    endcase
  endfunction

  logic          busy;
  logic [2:0]    mode_q;
  logic          mine_q, tw_q, vtw_q;
  logic [CW-1:0] cnt_q;

  wire start  = insn_valid & ~busy & ((insn == PLAIN_WORD) | (insn == MINE_WORD));
  wire active = start | busy;

  wire [2:0]    mode_s = busy ? mode_q : cur_mode;
  wire          mine_s = busy ? mine_q : (insn == MINE_WORD);
  wire          tw_s   = (busy ? tw_q : tw) & (HAS_UMODE != 0);
  wire          vtw_s  = busy ? vtw_q : vtw;
  wire [CW-1:0] cnt_s  = busy ? cnt_q : '0;
  wire [1:0]    cur_rank = rank_of(mode_s);

  logic [NUM_IRQ-1:0] lower;
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign lower[i] = irq_target[2*i +: 2] < cur_rank;
  end

  wire                selective = mine_s & (VARIANT_AS_PLAIN == 0);
  wire [NUM_IRQ-1:0]  filter    = selective ? ~lower : '1;
  wire                qual      = |(irq_pending & irq_enable & filter);

  logic       armed;
  logic [4:0] cause_sel;
  always_comb begin
    armed     = 1'b0;
    cause_sel = C_ILLEGAL;
    case (mode_s)
      MD_S:  armed = tw_s;
      MD_U:  armed = tw_s | (HAS_SMODE != 0);
      MD_VS: begin
        armed     = tw_s | vtw_s;
        cause_sel = tw_s ? C_ILLEGAL : C_VIRTUAL;
      end
      MD_VU: begin
        armed     = 1'b1;
        cause_sel = tw_s ? C_ILLEGAL : C_VIRTUAL;
      end
      default: ;
    endcase
  end

  wire timed_out = (cnt_s == LIMIT);
  wire fire_trap = active & armed & timed_out;
  wire fire_done = active & ~fire_trap & qual;
  wire resolve   = fire_trap | fire_done;

  assign wait_stall = active & ~resolve;
  assign wait_done  = fire_done;
  assign wait_exc   = fire_trap;
  assign exc_cause  = fire_trap ? cause_sel : 5'd0;

  wire [CW-1:0] cnt_nxt = timed_out ? cnt_s : cnt_s + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_q <= MD_M;
      mine_q <= 1'b0;
      tw_q   <= 1'b0;
      vtw_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (start && !resolve) begin
        busy   <= 1'b1;
        mode_q <= cur_mode;
        mine_q <= (insn == MINE_WORD);
        tw_q   <= tw;
        vtw_q  <= vtw;
      end else if (busy && resolve) begin
        busy <= 1'b0;
      end
      if (active && !resolve) cnt_q <= cnt_nxt;
    end
  end
endmodule

module wfi_wait_unit_chk #(
  parameter int NUM_IRQ = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               insn_valid,
  input logic [NUM_IRQ-1:0] irq_pending,
  input logic [NUM_IRQ-1:0] irq_enable,
  input logic               busy,
  input logic [2:0]         mode_q,
  input logic               wait_stall,
  input logic               wait_done,
  input logic               wait_exc,
  input logic [4:0]         exc_cause
);
  // R12
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_done && wait_exc));
  // R12
  stall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_done || wait_exc) |-> !wait_stall);
  // R12
  stall_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_stall |=> (wait_stall || wait_done || wait_exc));
  // R6
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_exc |-> (exc_cause == 5'd2 || exc_cause == 5'd22));
  // R2
  wake_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |-> |(irq_pending & irq_enable));
  // R5
  m_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == 3'd3) |-> !wait_exc);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !insn_valid) |-> !(wait_stall || wait_done || wait_exc));
endmodule

bind wfi_wait_unit wfi_wait_unit_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid),
  .irq_pending(irq_pending), .irq_enable(irq_enable),
  .busy(busy), .mode_q(mode_q),
  .wait_stall(wait_stall), .wait_done(wait_done),
  .wait_exc(wait_exc), .exc_cause(exc_cause)
);

// File: tb/wfi_wait_unit_test.sv
`timescale 1ns/1ps
module wfi_wait_unit_test;
  localparam int N = 16;
  localparam int TA = 4;
  localparam logic [31:0] PLAIN = 32'h1050_0073;
  localparam logic [31:0] MINE  = 32'h0050_0073;

  logic clk = 1'b0, rst_n = 1'b0;
  logic insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [2:0] cur_mode = 3'd3;
  logic tw = 1'b0, vtw = 1'b0;
  logic [N-1:0] pend = '0, en = '0;
  logic [2*N-1:0] tgt = '0;
  logic a_stall, a_done, a_exc, b_stall, b_done, b_exc;
  logic [4:0] a_cause, b_cause;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wfi_wait_unit #(.NUM_IRQ(N), .TIMEOUT_CYCLES(TA)) uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .cur_mode(cur_mode), .tw(tw), .vtw(vtw), .irq_pending(pend),
    .irq_enable(en), .irq_target(tgt), .wait_stall(a_stall),
    .wait_done(a_done), .wait_exc(a_exc), .exc_cause(a_cause));

  wfi_wait_unit #(.NUM_IRQ(N), .TIMEOUT_CYCLES(0), .VARIANT_AS_PLAIN(1)) uut_b (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .cur_mode(cur_mode), .tw(tw), .vtw(vtw), .irq_pending(pend),
    .irq_enable(en), .irq_target(tgt), .wait_stall(b_stall),
    .wait_done(b_done), .wait_exc(b_exc), .exc_cause(b_cause));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int rank(input logic [2:0] m);
    case (m)
      3'd1: return 2;
      3'd5: return 1;
      3'd0, 3'd4: return 0;
      default: return 3;
    endcase
  endfunction

  // kind: 0 done, 1 exception
  function automatic void predict(input bit mine, input bit as_plain, input int tmo,
      input logic [2:0] m, input bit t, input bit v, input logic [N-1:0] p,
      input logic [N-1:0] e, input logic [2*N-1:0] g, input int wake,
      output int kind, output int cyc, output int cause);
    bit qual = 0, armed = 0;
    cause = 2;
    for (int i = 0; i < N; i++)
      if (p[i] && e[i] && !(mine && !as_plain && int'(g[2*i +: 2]) < rank(m))) qual = 1;
    case (m)
      3'd1: armed = t;
      3'd0: armed = 1;
      3'd5: begin armed = t | v; cause = t ? 2 : 22; end
      3'd4: begin armed = 1; cause = t ? 2 : 22; end
      default: armed = 0;
    endcase
    if (armed && tmo == 0)          begin kind = 1; cyc = 0; end
    else if (qual)                  begin kind = 0; cyc = 0; end
    else if (armed && wake >= tmo)  begin kind = 1; cyc = tmo; end
    else                            begin kind = 0; cyc = wake; end
  endfunction

  function automatic logic [7:0] pack(input int kind, input int cause);
    return kind == 0 ? {3'b010, 5'd0} : {3'b001, 5'(cause)};
  endfunction

  // wake: interrupt 0 (target M) becomes pending+enabled in cycle `wake`
  task automatic run(input string req, input logic [31:0] w, input logic [2:0] m,
      input bit t, input bit v, input logic [N-1:0] p, input logic [N-1:0] e,
      input logic [2*N-1:0] g, input int wake, input int repulse);
    int ka, ca, za, kb, cb, zb;
    bit ra = 0, rb = 0;
    logic [N-1:0] p0 = p & ~N'(1);
    logic [N-1:0] e0 = e & ~N'(1);
    logic [2*N-1:0] g0 = {g[2*N-1:2], 2'd3};
    predict(w == MINE, 0, TA, m, t, v, p0 | (wake == 0 ? N'(1) : '0),
            e0 | (wake == 0 ? N'(1) : '0), g0, wake, ka, ca, za);
    predict(w == MINE, 1, 0, m, t, v, p0 | (wake == 0 ? N'(1) : '0),
            e0 | (wake == 0 ? N'(1) : '0), g0, wake, kb, cb, zb);
    @(negedge clk);
    insn = w; insn_valid = 1; cur_mode = m; tw = t; vtw = v; tgt = g0;
    pend = p0; en = e0;
    if (wake == 0) begin pend[0] = 1; en[0] = 1; end
    for (int c = 0; c < 64 && !(ra && rb); c++) begin
      #1;
      if (!ra) begin
        if (c == ca) begin
          check({a_stall, a_done, a_exc, a_cause} == pack(ka, za), req,
                {a_stall, a_done, a_exc, a_cause}, pack(ka, za));
          ra = 1;
        end else
          check({a_stall, a_done, a_exc} == 3'b100, req, {a_stall, a_done, a_exc}, 3'b100);
      end else
        check({a_stall, a_done, a_exc} == 3'b000, {req, " idle"}, {a_stall, a_done, a_exc}, 0);
      if (!rb) begin
        if (c == cb) begin
          check({b_stall, b_done, b_exc, b_cause} == pack(kb, zb), {req, " R4 inst_b"},
                {b_stall, b_done, b_exc, b_cause}, pack(kb, zb));
          rb = 1;
        end else
          check({b_stall, b_done, b_exc} == 3'b100, {req, " R4 inst_b"}, {b_stall, b_done, b_exc}, 3'b100);
      end else
        check({b_stall, b_done, b_exc} == 3'b000, {req, " inst_b idle"}, {b_stall, b_done, b_exc}, 0);
      @(negedge clk);
      insn_valid = 0;
      if (c + 1 == repulse) begin insn_valid = 1; insn = MINE; cur_mode = 3'd4; tw = 1; end
      if (c + 1 == wake) begin pend[0] = 1; en[0] = 1; end
    end
    insn_valid = 0; pend = '0; en = '0;
  endtask

  task automatic nonwait(input logic [31:0] w);
    @(negedge clk);
    insn = w; insn_valid = 1; cur_mode = 3'd4; tw = 1; pend = '0; en = '0;
    #1;
    check({a_stall, a_done, a_exc, b_stall, b_done, b_exc} == 6'b0, "R1 non-wait word",
          {a_stall, a_done, a_exc, b_stall, b_done, b_exc}, 0);
    @(negedge clk);
    insn_valid = 0;
    #1;
    check({a_stall, a_done, a_exc, b_stall, b_done, b_exc} == 6'b0, "R1 non-wait after",
          {a_stall, a_done, a_exc, b_stall, b_done, b_exc}, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] modes [5] = '{3'd0, 3'd1, 3'd3, 3'd4, 3'd5};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    check({a_stall, a_done, a_exc, a_cause} == 8'd0, "reset R1", {a_stall, a_done, a_exc, a_cause}, 0);
    rst_n = 1;
    nonwait(32'h3050_0073);
    nonwait(32'h1050_00F3);
    nonwait($urandom | 32'h0000_0004);
    // R2 ordinary wait, immediate and delayed wake in M mode
    run("R2 plain immediate", PLAIN, 3'd3, 0, 0, '0, '0, '0, 0, -1);
    run("R2 plain delayed", PLAIN, 3'd3, 0, 0, '0, '0, '0, 3, -1);
    // R3 variant in S with only U-routed interrupt pending
    run("R3 variant lower-routed", MINE, 3'd1, 0, 0, N'(16'h0008), N'(16'h0008), '0, 6, -1);
    run("R3 variant same-rank", MINE, 3'd1, 0, 0, N'(16'h0008), N'(16'h0008), {N{2'd2}}, 6, -1);
    // R5 M mode with TW set never traps; R12 repulse ignored
    run("R5 R12 M long stall", PLAIN, 3'd3, 1, 1, '0, '0, '0, 20, 3);
    run("R6 S TW timeout", PLAIN, 3'd1, 1, 0, '0, '0, '0, 9, -1);
    run("R7 U timeout", MINE, 3'd0, 0, 0, '0, '0, '0, 9, -1);
    run("R8 VS VTW", PLAIN, 3'd5, 0, 1, '0, '0, '0, 9, -1);
    run("R8 VS no intercept", PLAIN, 3'd5, 0, 0, '0, '0, '0, 9, -1);
    run("R9 VU", PLAIN, 3'd4, 0, 0, '0, '0, '0, 9, -1);
    run("R10 VS both bits", PLAIN, 3'd5, 1, 1, '0, '0, '0, 9, -1);
    run("R11 wake at limit", PLAIN, 3'd1, 1, 0, '0, '0, '0, TA, -1);
    run("R11 wake before limit", PLAIN, 3'd1, 1, 0, '0, '0, '0, TA - 1, -1);
    for (int k = 0; k < 300; k++) begin
      run("R12 random", ($urandom % 2) ? MINE : PLAIN, modes[$urandom % 5],
          1'($urandom), 1'($urandom), N'($urandom), N'($urandom), ($urandom),
          int'($urandom % 8), -1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule